// File: doc/BRIEF.md
# Access Level Bus Cycle Checker

This block screens each bus cycle of a paged memory management unit before the address is translated. A cycle presents a logical address, four function code bits, a read/write flag and the result of the address translation cache lookup (hit, a cached bus-error bit and a cached write-protect bit). When privilege checking is switched on, the block reads the privilege level that the address requests from its top one, two or three bits. It compares that level against the level held by the running task in a current-level register. Level 0 is the most privileged.

The block returns one registered verdict per cycle, on the clock after the cycle is presented:
- a bus error;
- permission to use the cached translation;
- a request to the table walker.

The walk request carries the function code and the full logical address, because cache entries are matched on all of those bits. The cache itself and the table walk are outside this block.

Top module: `alc_bus_checker`

## Requirements
- R1: `lvl_width_sel` sets the number of level bits: 2'b00 selects one bit, 2'b01 selects two, and 2'b10 or 2'b11 select three. The requested level is that many of the most significant bits of `cyc_addr`, read as an unsigned number.
- R2: A user cycle (`cyc_fc[3:2]` = 2'b00) with `lvl_enable` = 1 ends in `bus_error` if the requested level is numerically smaller than the current level. This holds whatever the cache inputs are.
- R3: A user cycle whose requested level is greater than or equal to the current level is not faulted by the level check. It goes on to the cache stage.
- R4: A supervisor cycle (`cyc_fc[3]` = 0, `cyc_fc[2]` = 1) skips the level check.
- R5: A DMA cycle (`cyc_fc[3]` = 1) skips the level check.
- R6: With `lvl_enable` = 0, no level check is made on any cycle.
- R7: A cycle that passes or skips the level check and hits in the cache with `atc_berr` = 1 ends in `bus_error`.
- R8: Such a hit with `atc_wp` = 1 ends in `bus_error` when `cyc_write` = 1. When `cyc_write` = 0 it ends in `translate_ok`, provided `atc_berr` = 0.
- R9: Such a hit with neither cached bit set ends in `translate_ok`.
- R10: Such a cycle that misses in the cache raises `walk_req`, with `walk_tag` = {`cyc_fc`, `cyc_addr`} of that cycle.
- R11: A write on the current-level port takes effect from the next cycle on; a cycle presented in the same cycle as the write is checked against the old value. Stored bits above the configured level width are ignored in the comparison.
- R12: The verdict appears on the clock edge after the cycle is presented and lasts one cycle. At most one of `bus_error`, `translate_ok` and `walk_req` is high. All three are low when no cycle was presented and after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cyc_valid | input | 1 | A bus cycle is presented |
| cyc_addr | input | ADDR_W | Logical address of the cycle |
| cyc_fc | input | 4 | Function code; bit 3 DMA, bit 2 supervisor |
| cyc_write | input | 1 | 1 for a write cycle |
| lvl_enable | input | 1 | Privilege level checking on |
| lvl_width_sel | input | 2 | Number of level bits in use |
| cal_wr_en | input | 1 | Load the current-level register |
| cal_wr_data | input | 3 | New current level |
| atc_hit | input | 1 | Exact cache match for this cycle |
| atc_berr | input | 1 | Bus-error bit of the matching entry |
| atc_wp | input | 1 | Write-protect bit of the matching entry |
| bus_error | output | 1 | Cycle terminated with a bus error |
| translate_ok | output | 1 | Cached translation may be issued |
| walk_req | output | 1 | Table walk requested |
| walk_tag | output | ADDR_W+4 | Function code and address for the walk |

## Verification
The assertions check the following on every cycle:
- the verdicts are mutually exclusive and silent after idle cycles;
- a level fault only arises on enabled user cycles, and always yields a bus error;
- supervisor and DMA cycles with a clean hit reach `translate_ok`;
- a cached bus-error bit always aborts the cycle;
- the walk tag matches the cycle that raised it;
- a current-level write lands a cycle later.

Only the bench scenarios can show the following:
- the numeric boundary of the comparison at each of the three widths;
- the masking of current-level bits above the selected width;
- the old-value rule when a level write and a cycle coincide.

// File: rtl/alc_pkg.sv
package alc_pkg;

  localparam int LVL_MAX_W = 3;

  typedef enum logic [1:0] {
    V_NONE  = 2'd0,
    V_FAULT = 2'd1,
    V_GO    = 2'd2,
    V_WALK  = 2'd3
  } verdict_e;

  // number of level bits chosen by the width select
  function automatic logic [1:0] lvl_count(input logic [1:0] sel);
    case (sel)
      2'b00:   lvl_count = 2'd1;
      2'b01:   lvl_count = 2'd2;
      default: lvl_count = 2'd3;
    endcase
  endfunction

  // mask keeping the low bits that take part in a level compare
  function automatic logic [LVL_MAX_W-1:0] lvl_mask(input logic [1:0] sel);
    lvl_mask = LVL_MAX_W'((4'd1 << lvl_count(sel)) - 4'd1);
  endfunction

  // right-aligns the top bits of an address window of LVL_MAX_W bits
  function automatic logic [LVL_MAX_W-1:0] lvl_from_top(input logic [LVL_MAX_W-1:0] top,
                                                        input logic [1:0] sel);
    lvl_from_top = top >> (2'd3 - lvl_count(sel));
  endfunction

  // true when the requested level asks for more privilege than held
  function automatic logic lvl_too_high(input logic [LVL_MAX_W-1:0] req,
                                        input logic [LVL_MAX_W-1:0] held);
    lvl_too_high = (req < held);
  endfunction

endpackage

// File: rtl/alc_level_extract.sv
module alc_level_extract
  import alc_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0]    addr,
  input  logic [1:0]           width_sel,
  output logic [LVL_MAX_W-1:0] req_lvl
);
  logic [LVL_MAX_W-1:0] top_bits;

  always_comb begin
    top_bits = addr[ADDR_W-1 -: LVL_MAX_W];
    req_lvl  = lvl_from_top(top_bits, width_sel);
  end
endmodule

// File: rtl/alc_cal_reg.sv
module alc_cal_reg
  import alc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [LVL_MAX_W-1:0] wr_data,
  input  logic [1:0]           width_sel,
  output logic [LVL_MAX_W-1:0] cal_q,
  output logic [LVL_MAX_W-1:0] cal_eff
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cal_q <= '0;
    else if (wr_en) cal_q <= wr_data;
  end

  assign cal_eff = cal_q & lvl_mask(width_sel);
endmodule

// File: rtl/alc_verdict.sv
module alc_verdict
  import alc_pkg::*;
(
  input  logic                 valid,
  input  logic [1:0]           fc_hi,
  input  logic                 write,
  input  logic                 enable,
  input  logic [LVL_MAX_W-1:0] req_lvl,
  input  logic [LVL_MAX_W-1:0] cal_eff,
  input  logic                 hit,
  input  logic                 hit_berr,
  input  logic                 hit_wp,
  output logic                 lvl_checked,
  output logic                 lvl_fault,
  output logic                 cache_fault,
  output verdict_e             verdict
);
  always_comb begin
    lvl_checked = valid && enable && (fc_hi == 2'b00);
    lvl_fault   = lvl_checked && lvl_too_high(req_lvl, cal_eff);
    cache_fault = hit && (hit_berr || (hit_wp && write));
    if (!valid)          verdict = V_NONE;
    else if (lvl_fault)  verdict = V_FAULT;
    else if (!hit)       verdict = V_WALK;
    else if (cache_fault) verdict = V_FAULT;
    else                 verdict = V_GO;
  end
endmodule

// File: rtl/alc_bus_checker.sv
module alc_bus_checker
  import alc_pkg::*;
#(
  parameter int ADDR_W = 32,
  localparam int TAG_W = ADDR_W + 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cyc_valid,
  input  logic [ADDR_W-1:0] cyc_addr,
  input  logic [3:0]        cyc_fc,
  input  logic              cyc_write,
  input  logic              lvl_enable,
  input  logic [1:0]        lvl_width_sel,
  input  logic              cal_wr_en,
  input  logic [2:0]        cal_wr_data,
  input  logic              atc_hit,
  input  logic              atc_berr,
  input  logic              atc_wp,
  output logic              bus_error,
  output logic              translate_ok,
  output logic              walk_req,
  output logic [TAG_W-1:0]  walk_tag
);
  logic [LVL_MAX_W-1:0] req_lvl;
  logic [LVL_MAX_W-1:0] cal_q;
  logic [LVL_MAX_W-1:0] cal_eff;
  logic                 lvl_checked;
  logic                 lvl_fault;
  logic                 cache_fault;
  verdict_e             verdict;

  alc_level_extract #(.ADDR_W(ADDR_W)) u_extract (
    .addr      (cyc_addr),
    .width_sel (lvl_width_sel),
    .req_lvl   (req_lvl)
  );

  alc_cal_reg u_cal (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (cal_wr_en),
    .wr_data   (cal_wr_data),
    .width_sel (lvl_width_sel),
    .cal_q     (cal_q),
    .cal_eff   (cal_eff)
  );

  alc_verdict u_verdict (
    .valid       (cyc_valid),
    .fc_hi       (cyc_fc[3:2]),
    .write       (cyc_write),
    .enable      (lvl_enable),
    .req_lvl     (req_lvl),
    .cal_eff     (cal_eff),
    .hit         (atc_hit),
    .hit_berr    (atc_berr),
    .hit_wp      (atc_wp),
    .lvl_checked (lvl_checked),
    .lvl_fault   (lvl_fault),
    .cache_fault (cache_fault),
    .verdict     (verdict)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_error    <= 1'b0;
      translate_ok <= 1'b0;
      walk_req     <= 1'b0;
      walk_tag     <= '0;
    end else begin
      bus_error    <= (verdict == V_FAULT);
      translate_ok <= (verdict == V_GO);
      walk_req     <= (verdict == V_WALK);
      if (verdict == V_WALK) walk_tag <= {cyc_fc, cyc_addr};
    end
  end
endmodule

// File: rtl/alc_bus_checker_chk.sv
module alc_bus_checker_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cyc_valid,
  input logic [ADDR_W-1:0] cyc_addr,
  input logic [3:0]        cyc_fc,
  input logic              cyc_write,
  input logic              lvl_enable,
  input logic              cal_wr_en,
  input logic [2:0]        cal_wr_data,
  input logic              atc_hit,
  input logic              atc_berr,
  input logic              atc_wp,
  input logic              bus_error,
  input logic              translate_ok,
  input logic              walk_req,
  input logic [ADDR_W+3:0] walk_tag,
  input logic [2:0]        cal_q,
  input logic              lvl_fault
);
  // R12
  verdict_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({bus_error, translate_ok, walk_req}));

  // R12
  idle_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_valid |=> !(bus_error || translate_ok || walk_req));

  // R2
  fault_scope_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_fault |-> (lvl_enable && cyc_fc[3:2] == 2'b00));

  // R2
  fault_aborts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_fault |=> bus_error);

  // R4
  super_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && cyc_fc[3:2] == 2'b01 && atc_hit && !atc_berr && !(atc_wp && cyc_write))
    |=> translate_ok);

  // R5
  dma_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && cyc_fc[3] && atc_hit && !atc_berr && !(atc_wp && cyc_write))
    |=> translate_ok);

  // R6
  disabled_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && !lvl_enable && !atc_hit) |=> walk_req);

  // R7
  cached_berr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && atc_hit && atc_berr) |=> bus_error);

  // R10
  walk_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && !lvl_fault && !atc_hit) |=> (walk_tag == $past({cyc_fc, cyc_addr})));

  // R11
  cal_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cal_wr_en |=> (cal_q == $past(cal_wr_data)));
endmodule

bind alc_bus_checker alc_bus_checker_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cyc_valid    (cyc_valid),
  .cyc_addr     (cyc_addr),
  .cyc_fc       (cyc_fc),
  .cyc_write    (cyc_write),
  .lvl_enable   (lvl_enable),
  .cal_wr_en    (cal_wr_en),
  .cal_wr_data  (cal_wr_data),
  .atc_hit      (atc_hit),
  .atc_berr     (atc_berr),
  .atc_wp       (atc_wp),
  .bus_error    (bus_error),
  .translate_ok (translate_ok),
  .walk_req     (walk_req),
  .walk_tag     (walk_tag),
  .cal_q        (cal_q),
  .lvl_fault    (lvl_fault)
);

// File: tb/tb_alc_bus_checker.sv
module tb_alc_bus_checker;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cyc_valid = 1'b0;
  logic [AW-1:0] cyc_addr = '0;
  logic [3:0]    cyc_fc = '0;
  logic          cyc_write = 1'b0;
  logic          lvl_enable = 1'b0;
  logic [1:0]    lvl_width_sel = '0;
  logic          cal_wr_en = 1'b0;
  logic [2:0]    cal_wr_data = '0;
  logic          atc_hit = 1'b0;
  logic          atc_berr = 1'b0;
  logic          atc_wp = 1'b0;
  logic          bus_error, translate_ok, walk_req;
  logic [AW+3:0] walk_tag;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  logic [2:0] cal_model = '0;

  always #4 clk = ~clk;

  alc_bus_checker #(.ADDR_W(AW)) dut (.*);

  // expected code: 0 nothing, 1 bus error, 2 translate, 3 walk
  function automatic int model(input logic v, input logic [AW-1:0] a, input logic [3:0] fc,
                               input logic wr, input logic en, input logic [1:0] ws,
                               input logic [2:0] cal, input logic h, input logic hb,
                               input logic hw);
    int n;
    int req;
    int held;
    if (!v) return 0;
    n = (ws == 2'b00) ? 1 : (ws == 2'b01) ? 2 : 3;
    req = int'(a >> (AW - n));
    held = int'(cal) % (1 << n);
    if (en && !fc[3] && !fc[2] && req < held) return 1;
    if (!h) return 3;
    if (hb || (hw && wr)) return 1;
    return 2;
  endfunction

  function automatic int observed();
    if (bus_error) return translate_ok || walk_req ? 9 : 1;
    if (translate_ok) return walk_req ? 9 : 2;
    if (walk_req) return 3;
    return 0;
  endfunction

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, got, exp);
    end
  endtask

  // presents one cycle at a falling edge and checks the verdict one clock later
  task automatic run(input string req, input logic v, input logic [AW-1:0] a,
                     input logic [3:0] fc, input logic wr, input logic en,
                     input logic [1:0] ws, input logic h, input logic hb, input logic hw,
                     input logic cw, input logic [2:0] cd, input int exp_override);
    int exp;
    cyc_valid = v; cyc_addr = a; cyc_fc = fc; cyc_write = wr;
    lvl_enable = en; lvl_width_sel = ws; atc_hit = h; atc_berr = hb; atc_wp = hw;
    cal_wr_en = cw; cal_wr_data = cd;
    exp = (exp_override >= 0) ? exp_override : model(v, a, fc, wr, en, ws, cal_model, h, hb, hw);
    if (cw) cal_model = cd;
    @(negedge clk);
    check(req, observed(), exp);
    if (exp == 3) check({req, " tag"}, int'(walk_tag == {fc, a}), 1);
  endtask

  task automatic set_cal(input logic [2:0] v);
    run("R11", 1'b0, '0, 4'h0, 1'b0, 1'b0, 2'b10, 1'b0, 1'b0, 1'b0, 1'b1, v, 0);
  endtask

  initial begin
    while (cycles < 150000) begin
      @(posedge clk);
      cycles++;
    end
    fails++;
    $display("FAIL watchdog actual=%0d expected=<150000", cycles);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    // R12: reset state
    check("R12 reset", observed(), 0);
    check("R12 reset tag", int'(walk_tag == '0), 1);
    rst_n = 1'b1;
    @(negedge clk);

    // R1/R2/R3: three-bit levels, current level 5
    set_cal(3'd5);
    run("R2", 1'b1, 32'h8000_0000, 4'h1, 1'b0, 1'b1, 2'b10, 1'b1, 1'b0, 1'b0, 1'b0, '0, 1);
    run("R3", 1'b1, 32'hA000_0000, 4'h1, 1'b0, 1'b1, 2'b10, 1'b1, 1'b0, 1'b0, 1'b0, '0, 2);
    run("R1", 1'b1, 32'hE000_0010, 4'h2, 1'b1, 1'b1, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, '0, 3);
    // R4/R5/R6: level 0 address with level 5 held
    run("R4", 1'b1, 32'h0000_1000, 4'h5, 1'b0, 1'b1, 2'b10, 1'b1, 1'b0, 1'b0, 1'b0, '0, 2);
    run("R5", 1'b1, 32'h0000_1000, 4'h8, 1'b0, 1'b1, 2'b10, 1'b0, 1'b0, 1'b0, 1'b0, '0, 3);
    run("R6", 1'b1, 32'h0000_1000, 4'h1, 1'b0, 1'b0, 2'b10, 1'b1, 1'b0, 1'b0, 1'b0, '0, 2);
    // R2: level fault wins over a clean hit and over a miss
    run("R2 miss", 1'b1, 32'h1FFF_FFFF, 4'h2, 1'b1, 1'b1, 2'b10, 1'b0, 1'b0, 1'b0, 1'b0, '0, 1);
    // R7/R8/R9 on a passing user cycle
    run("R7", 1'b1, 32'hC000_0000, 4'h1, 1'b0, 1'b1, 2'b10, 1'b1, 1'b1, 1'b0, 1'b0, '0, 1);
    run("R8 write", 1'b1, 32'hC000_0000, 4'h1, 1'b1, 1'b1, 2'b10, 1'b1, 1'b0, 1'b1, 1'b0, '0, 1);
    run("R8 read", 1'b1, 32'hC000_0000, 4'h1, 1'b0, 1'b1, 2'b10, 1'b1, 1'b0, 1'b1, 1'b0, '0, 2);
    run("R9", 1'b1, 32'hC000_0000, 4'h1, 1'b1, 1'b1, 2'b10, 1'b1, 1'b0, 1'b0, 1'b0, '0, 2);
    // R7 on a supervisor cycle
    run("R7 super", 1'b1, 32'h0, 4'h6, 1'b0, 1'b1, 2'b10, 1'b1, 1'b1, 1'b0, 1'b0, '0, 1);
    // R12: idle cycle yields nothing
    run("R12 idle", 1'b0, 32'h0, 4'h1, 1'b0, 1'b1, 2'b10, 1'b1, 1'b0, 1'b0, 1'b0, '0, 0);
    // R11: masking; held 6, one-bit width -> effective 0, so top bit 0 passes
    set_cal(3'd6);
    run("R11 mask1", 1'b1, 32'h0000_0000, 4'h1, 1'b0, 1'b1, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0, '0, 2);
    // two-bit width -> effective 2; level 1 faults, level 2 passes
    run("R1 w2 lo", 1'b1, 32'h4000_0000, 4'h1, 1'b0, 1'b1, 2'b01, 1'b1, 1'b0, 1'b0, 1'b0, '0, 1);
    run("R1 w2 eq", 1'b1, 32'h8000_0000, 4'h1, 1'b0, 1'b1, 2'b01, 1'b1, 1'b0, 1'b0, 1'b0, '0, 2);
    // R11: a cycle beside a write sees the old level (6), the next sees 1
    run("R11 old", 1'b1, 32'h2000_0000, 4'h1, 1'b0, 1'b1, 2'b10, 1'b1, 1'b0, 1'b0, 1'b1, 3'd1, 1);
    run("R11 new", 1'b1, 32'h2000_0000, 4'h1, 1'b0, 1'b1, 2'b10, 1'b1, 1'b0, 1'b0, 1'b0, '0, 2);

    // random mix checked against the bench model
    for (int i = 0; i < 3000; i++) begin
      logic [3:0] fc;
      fc = 4'($urandom);
      if ($urandom % 2 == 0) fc[3:2] = 2'b00;
      run("R2 R10 random", ($urandom % 5) != 0, $urandom, fc, 1'($urandom), ($urandom % 4) != 0,
          2'($urandom), 1'($urandom), ($urandom % 4) == 0, ($urandom % 3) == 0,
          ($urandom % 6) == 0, 3'($urandom), -1);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule